// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-port synchronous static memory whose address, control and write data are all captured on the rising clock edge, and whose read data leaves through an output register. A read therefore takes two edges from the cycle that presents it to the cycle where the word sits on the read bus. The low two address bits come from an internal burst counter, so a host can present one address and then pulse an advance input to walk through a four-word group. The walk is either sequential with wrap-around or XOR-interleaved.

A cycle opens through one of two strobes. The processor strobe always opens a read and wins when both strobes are high. The controller strobe opens a read or a write, depending on the write controls. Three chip selects must all be active for a strobe to open a cycle. A strobe seen while the device is not selected closes the current cycle, and the read bus is released one edge after that. Writes reach the four byte lanes either one by one, under a lane-enable qualifier, or all at once under a global write. An output enable gates the read bus without waiting for a clock. A snooze input freezes all traffic while the array keeps its contents.

Top module: `psb_sram`

## Requirements
- R1: A read cycle registered at edge k places the addressed word on `rd_data`, with `rd_oe` high, after edge k+1 (when `rd_en` is high and `snooze` is low).
- R2: `strobe_ctl` with the device selected and `strobe_cpu` low opens a cycle at `addr`. The cycle writes when any lane is enabled and reads otherwise.
- R3: `strobe_cpu` with the device selected opens a read at `addr` and wins over `strobe_ctl`. In that cycle all write controls are ignored.
- R4: With `burst_ilv` low at the opening edge, each `adv` in a continuing cycle sets the low two address bits to (start + steps) mod 4. The upper address bits stay unchanged.
- R5: With `burst_ilv` high at the opening edge, each `adv` sets the low two address bits to start XOR steps.
- R6: With `all_we` low, lane i (bits 8i+7..8i) is written only when both `lane_wr_en` and `lane_we[i]` are high. With `all_we` and `lane_wr_en` both low, the cycle is a read.
- R7: `all_we` high writes all four lanes, whatever `lane_wr_en` and `lane_we` are.
- R8: The device is selected when `sel_a`=1, `sel_b`=1 and `sel_cn`=0. A strobe seen while the device is not selected ends the cycle: `rd_oe` stays high after that edge and goes low after the next one.
- R9: `rd_en` low forces `rd_oe` low and `rd_data` to zero at once, with no clock edge needed.
- R10: While `snooze` is high, `rd_oe` is low at once and no read or write takes place. The array keeps its contents, and strobes act again from the first edge after `snooze` falls.
- R11: After synchronous reset `rd_oe` is low and no cycle is open.
- R12: In an open cycle with no strobe and no `adv`, the address is held and each further cycle repeats the access at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address sampled with a strobe |
| strobe_cpu | input | 1 | Processor strobe, opens a read, highest priority |
| strobe_ctl | input | 1 | Controller strobe, opens a read or write |
| adv | input | 1 | Steps the burst counter in an open cycle |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_cn | input | 1 | Chip select, active low |
| lane_wr_en | input | 1 | Qualifies the per-lane write enables |
| lane_we | input | 4 | Per-lane write enables, bit i = lane i |
| all_we | input | 1 | Global write of all lanes |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Asynchronous output enable |
| snooze | input | 1 | Standby: freezes traffic, releases the bus |
| rd_data | output | DATA_W | Read data, zero when not driven |
| rd_oe | output | 1 | Read bus drive enable |

## Verification
Read data is due on the second rising edge after the edge that registers the read. The bench therefore samples at the falling edge that follows that second edge. A bench model, updated at each rising edge, holds the open-cycle state, the pending write and the output register. At every falling edge the drive enable and data are compared with this model, before new inputs are applied. The output-enable and snooze gating act without a clock. They are checked one time unit after the input changes, with no clock edge in between. Writes are confirmed by later reads through the normal strobe path.

// File: rtl/psb_pkg.sv
package psb_pkg;

    localparam int LANES  = 4;
    localparam int OFFS_W = 2;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_CPU  = 2'd1,
        CYC_CTL  = 2'd2,
        CYC_CONT = 2'd3
    } cyc_kind_t;

    typedef struct packed {
        logic              active;
        logic              wr;
        logic              ilv;
        logic [OFFS_W-1:0] steps;
    } stage_t;

    function automatic logic [OFFS_W-1:0] burst_off(
        input logic [OFFS_W-1:0] start,
        input logic [OFFS_W-1:0] steps,
        input logic              ilv
    );
        return ilv ? (start ^ steps) : (start + steps);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(
        input logic             glob,
        input logic             qual,
        input logic [LANES-1:0] lanes
    );
        if (glob)      return '1;
        else if (qual) return lanes;
        else           return '0;
    endfunction

endpackage

// File: rtl/psb_ctrl.sv
module psb_ctrl
    import psb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snooze,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              adv,
    input  logic              burst_ilv,
    input  logic              sel,
    input  logic [LANES-1:0]  mask_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic              active_o,
    output logic              wr_o,
    output logic [LANES-1:0]  mask_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [ADDR_W-1:0] eff_addr_o
);

    stage_t            st;
    logic [ADDR_W-1:0] base;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] wdata_q;
    cyc_kind_t         kind;

    always_comb begin
        if (strobe_cpu)      kind = CYC_CPU;
        else if (strobe_ctl) kind = CYC_CTL;
        else if (st.active)  kind = CYC_CONT;
        else                 kind = CYC_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            base    <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
        end else if (snooze) begin
            st.active <= 1'b0;
            st.wr     <= 1'b0;
        end else begin
            case (kind)
                CYC_CPU: begin
                    st.wr <= 1'b0;
                    st.active <= sel;
                    if (sel) begin
                        base     <= addr;
                        st.steps <= '0;
                        st.ilv   <= burst_ilv;
                    end
                end
                CYC_CTL: begin
                    st.active <= sel;
                    st.wr     <= sel && (mask_in != '0);
                    if (sel) begin
                        base     <= addr;
                        st.steps <= '0;
                        st.ilv   <= burst_ilv;
                        mask_q   <= mask_in;
                        wdata_q  <= wdata_in;
                    end
                end
                CYC_CONT: begin
                    if (adv) st.steps <= st.steps + 1'b1;
                    st.wr   <= (mask_in != '0);
                    mask_q  <= mask_in;
                    wdata_q <= wdata_in;
                end
                default: st.wr <= 1'b0;
            endcase
        end
    end

    assign active_o   = st.active;
    assign wr_o       = st.wr;
    assign mask_o     = mask_q;
    assign wdata_o    = wdata_q;
    assign eff_addr_o = {base[ADDR_W-1:OFFS_W], burst_off(base[OFFS_W-1:0], st.steps, st.ilv)};

    AST_CPU_WINS: assert property (@(posedge clk) disable iff (rst)
        (strobe_cpu && sel && !snooze) |=> (active_o && !wr_o)); // R3

    AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
        ((strobe_cpu || strobe_ctl) && !sel && !snooze) |=> !active_o); // R8

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_CONT && adv && !st.ilv && !snooze)
        |=> (eff_addr_o[1:0] == $past(eff_addr_o[1:0]) + 2'd1)); // R4

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_CONT && !snooze)
        |=> (eff_addr_o[ADDR_W-1:OFFS_W] == $past(eff_addr_o[ADDR_W-1:OFFS_W]))); // R4

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_CONT && !adv && !snooze) |=> $stable(eff_addr_o)); // R12

    AST_SNOOZE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        snooze |=> (!active_o && !wr_o)); // R10

endmodule

// File: rtl/psb_array.sv
module psb_array
    import psb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[g]) lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[addr];
    end

    AST_WRITE_HAS_LANE: assert property (@(posedge clk)
        we |-> (mask != '0)); // R6

endmodule

// File: rtl/psb_outreg.sv
module psb_outreg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snooze,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rdata_in,
    input  logic              rd_en,
    output logic [DATA_W-1:0] q_data,
    output logic              q_oe
);

    logic              q_vld;
    logic [DATA_W-1:0] q_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld <= 1'b0;
            q_reg <= '0;
        end else if (snooze) begin
            q_vld <= 1'b0;
        end else begin
            q_vld <= rd_req;
            if (rd_req) q_reg <= rdata_in;
        end
    end

    assign q_oe   = q_vld && rd_en && !snooze;
    assign q_data = q_oe ? q_reg : '0;

    AST_DRIVE_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !snooze) |=> q_vld); // R1

    AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (!q_oe && q_data == '0)); // R9

endmodule

// File: rtl/psb_sram.sv
module psb_sram
    import psb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              adv,
    input  logic              burst_ilv,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_cn,
    input  logic              lane_wr_en,
    input  logic [3:0]        lane_we,
    input  logic              all_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              snooze,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    logic              sel;
    logic [LANES-1:0]  mask_in;
    logic              active_s;
    logic              wr_s;
    logic [LANES-1:0]  mask_s;
    logic [DATA_W-1:0] wdata_s;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] arr_rdata;

    assign sel     = sel_a && sel_b && !sel_cn;
    assign mask_in = lane_mask(all_we, lane_wr_en, lane_we);

    psb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .snooze     (snooze),
        .addr       (addr),
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .adv        (adv),
        .burst_ilv  (burst_ilv),
        .sel        (sel),
        .mask_in    (mask_in),
        .wdata_in   (wr_data),
        .active_o   (active_s),
        .wr_o       (wr_s),
        .mask_o     (mask_s),
        .wdata_o    (wdata_s),
        .eff_addr_o (eff_addr)
    );

    psb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (wr_s && !snooze),
        .mask  (mask_s),
        .addr  (eff_addr),
        .wdata (wdata_s),
        .rdata (arr_rdata)
    );

    psb_outreg #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .snooze   (snooze),
        .rd_req   (active_s && !wr_s),
        .rdata_in (arr_rdata),
        .rd_en    (rd_en),
        .q_data   (rd_data),
        .q_oe     (rd_oe)
    );

    AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (rst)
        (strobe_ctl && !strobe_cpu && sel && all_we && !snooze)
        |=> (wr_s && mask_s == '1)); // R7

    AST_NO_QUAL_READS: assert property (@(posedge clk) disable iff (rst)
        (!all_we && !lane_wr_en) |=> !wr_s); // R6

    AST_CTL_OPENS: assert property (@(posedge clk) disable iff (rst)
        (strobe_ctl && !strobe_cpu && sel && !snooze) |=> active_s); // R2

    AST_SNOOZE_QUIET: assert property (@(posedge clk) disable iff (rst)
        snooze |-> !rd_oe); // R10

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!rd_oe && !active_s)); // R11

endmodule

// File: tb/psb_sram_tb.sv
module psb_sram_tb_top;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr;
    logic              s_cpu, s_ctl, adv, ilv;
    logic              sel_a, sel_b, sel_cn;
    logic              bwe, gwe, oe, zz;
    logic [3:0]        lane_we;
    logic [DATA_W-1:0] wd;
    logic [DATA_W-1:0] rd_data;
    logic              rd_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    psb_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .strobe_cpu(s_cpu), .strobe_ctl(s_ctl),
        .adv(adv), .burst_ilv(ilv), .sel_a(sel_a), .sel_b(sel_b), .sel_cn(sel_cn),
        .lane_wr_en(bwe), .lane_we(lane_we), .all_we(gwe), .wr_data(wd),
        .rd_en(oe), .snooze(zz), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    // Bench model built from the requirements
    logic              m_act, m_wr, m_ilv, m_drv;
    logic [1:0]        m_cnt;
    logic [ADDR_W-1:0] m_base;
    logic [3:0]        m_mask;
    logic [DATA_W-1:0] m_wd, m_q;
    logic [DATA_W-1:0] mem_m [DEPTH];

    function automatic logic [ADDR_W-1:0] m_eff();
        logic [1:0] off;
        off = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[ADDR_W-1:2], off};
    endfunction

    function automatic logic [3:0] m_lanes();
        if (gwe) return 4'hF;
        if (bwe) return lane_we;
        return 4'h0;
    endfunction

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                                input logic [DATA_W-1:0] nw,
                                                input logic [3:0] m);
        logic [DATA_W-1:0] r;
        r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    initial begin
        m_act = 0; m_wr = 0; m_ilv = 0; m_drv = 0; m_cnt = 0;
        m_base = '0; m_mask = 0; m_wd = '0; m_q = '0;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    end

    always @(posedge clk) begin
        logic [ADDR_W-1:0] ea;
        logic sel;
        sel = sel_a && sel_b && !sel_cn;
        ea  = m_eff();
        if (rst) begin
            m_act = 0; m_wr = 0; m_drv = 0; m_cnt = 0;
        end else if (zz) begin
            m_act = 0; m_wr = 0; m_drv = 0;
        end else begin
            if (m_wr) mem_m[ea] = merge(mem_m[ea], m_wd, m_mask);
            m_drv = m_act && !m_wr;
            if (m_drv) m_q = mem_m[ea];
            if (s_cpu) begin
                m_act = sel; m_wr = 0;
                if (sel) begin m_base = addr; m_cnt = 0; m_ilv = ilv; end
            end else if (s_ctl) begin
                m_act = sel; m_wr = sel && (m_lanes() != 0);
                if (sel) begin
                    m_base = addr; m_cnt = 0; m_ilv = ilv;
                    m_mask = m_lanes(); m_wd = wd;
                end
            end else if (m_act) begin
                if (adv) m_cnt = m_cnt + 1;
                m_wr = (m_lanes() != 0); m_mask = m_lanes(); m_wd = wd;
            end else begin
                m_wr = 0;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock; sample at the following falling edge against the model
    task automatic step(input string req);
        logic eoe;
        @(posedge clk);
        @(negedge clk);
        eoe = m_drv && oe && !zz;
        check(req, "rd_oe", {31'd0, rd_oe}, {31'd0, eoe});
        if (eoe) check(req, "rd_data", rd_data, m_q);
    endtask

    task automatic idle_in();
        s_cpu = 0; s_ctl = 0; adv = 0; bwe = 0; gwe = 0; lane_we = 0; wd = '0;
    endtask

    task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        idle_in(); s_ctl = 1; addr = a; gwe = 1; wd = d;
        step("R2");
        idle_in();
        step("R2");
    endtask

    task automatic rd_word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                           input string req);
        idle_in(); s_ctl = 1; addr = a;
        step(req);
        idle_in();
        step(req);
        check(req, "read word", rd_data, exp);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; addr = '0; ilv = 0; sel_a = 1; sel_b = 1; sel_cn = 0; oe = 1; zz = 0;
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R11", "rd_oe after reset", {31'd0, rd_oe}, '0);
        step("R11");

        // R2 single words
        wr_word(8'h10, 32'hCAFE0001);
        rd_word(8'h10, 32'hCAFE0001, "R2");

        // R4 linear burst from offset 2: 22,23,20,21
        idle_in(); ilv = 0; s_ctl = 1; addr = 8'h22; gwe = 1; wd = 32'h11111111;
        step("R4");
        for (int k = 2; k <= 4; k++) begin
            idle_in(); adv = 1; gwe = 1; wd = 32'h11111111 * k; step("R4");
        end
        idle_in(); step("R4");
        rd_word(8'h20, 32'h33333333, "R4");
        rd_word(8'h21, 32'h44444444, "R4");
        rd_word(8'h23, 32'h22222222, "R4");

        // R5 interleaved burst from offset 3: 43,42,41,40
        idle_in(); ilv = 1; s_ctl = 1; addr = 8'h43; gwe = 1; wd = 32'hA0000001;
        step("R5");
        for (int k = 2; k <= 4; k++) begin
            idle_in(); adv = 1; gwe = 1; wd = 32'hA0000000 + k; step("R5");
        end
        idle_in(); step("R5");
        ilv = 0;
        rd_word(8'h40, 32'hA0000004, "R5");
        rd_word(8'h42, 32'hA0000002, "R5");

        // R5 read back in interleaved order with the processor strobe
        idle_in(); ilv = 1; s_cpu = 1; addr = 8'h41; step("R5");
        for (int k = 0; k < 3; k++) begin idle_in(); adv = 1; step("R5"); end
        idle_in(); step("R5");
        ilv = 0;

        // R6 per-lane writes (lane i = bits 8i+7..8i)
        wr_word(8'h50, 32'hAAAAAAAA);
        idle_in(); s_ctl = 1; addr = 8'h50; bwe = 1; lane_we = 4'b0101; wd = 32'h11223344;
        step("R6"); idle_in(); step("R6");
        rd_word(8'h50, 32'hAA22AA44, "R6");
        idle_in(); s_ctl = 1; addr = 8'h50; bwe = 0; lane_we = 4'b1111; wd = 32'h0;
        step("R6"); idle_in(); step("R6");
        check("R6", "unqualified lanes read", rd_data, 32'hAA22AA44);

        // R7 global write over lane controls
        idle_in(); s_ctl = 1; addr = 8'h50; gwe = 1; bwe = 0; lane_we = 0; wd = 32'h5A5A5A5A;
        step("R7"); idle_in(); step("R7");
        rd_word(8'h50, 32'h5A5A5A5A, "R7");

        // R3 both strobes: read wins, write ignored
        idle_in(); s_cpu = 1; s_ctl = 1; addr = 8'h50; gwe = 1; wd = 32'h0;
        step("R3"); idle_in(); step("R3");
        check("R3", "priority read", rd_data, 32'h5A5A5A5A);
        rd_word(8'h50, 32'h5A5A5A5A, "R3");

        // R12 hold: repeated reads at the same address
        rd_word(8'h10, 32'hCAFE0001, "R12");
        for (int k = 0; k < 3; k++) begin
            step("R12");
            check("R12", "held word", rd_data, 32'hCAFE0001);
        end

        // R8 deselect: driven after the deselect edge, released after the next
        idle_in(); s_cpu = 1; sel_a = 0; addr = 8'h10;
        step("R8");
        check("R8", "still driven", {31'd0, rd_oe}, 32'd1);
        idle_in(); sel_a = 1;
        step("R8");
        check("R8", "released", {31'd0, rd_oe}, 32'd0);
        idle_in(); s_ctl = 1; sel_cn = 1; addr = 8'h10; step("R8");
        idle_in(); sel_cn = 0; step("R8");
        check("R8", "ctl strobe unselected", {31'd0, rd_oe}, 32'd0);

        // R9 asynchronous output enable
        rd_word(8'h10, 32'hCAFE0001, "R9");
        #2 oe = 0; #1;
        check("R9", "oe low", {31'd0, rd_oe}, 32'd0);
        check("R9", "data zero", rd_data, 32'd0);
        oe = 1; #1;
        check("R9", "oe back", {31'd0, rd_oe}, 32'd1);
        @(negedge clk);

        // R10 snooze
        wr_word(8'h60, 32'h60606060);
        rd_word(8'h60, 32'h60606060, "R10");
        #2 zz = 1; #1;
        check("R10", "bus off at once", {31'd0, rd_oe}, 32'd0);
        @(negedge clk);
        idle_in(); s_ctl = 1; addr = 8'h60; gwe = 1; wd = 32'hDEADBEEF;
        step("R10");
        idle_in(); step("R10"); step("R10");
        zz = 0;
        step("R10");
        check("R10", "no drive after release", {31'd0, rd_oe}, 32'd0);
        rd_word(8'h60, 32'h60606060, "R10");

        // R1 constrained random traffic against the model
        for (int n = 0; n < 2000; n++) begin
            s_cpu   = ($urandom % 8) == 0;
            s_ctl   = ($urandom % 5) == 0;
            adv     = ($urandom % 2) == 0;
            ilv     = ($urandom % 2) == 0;
            sel_a   = ($urandom % 10) != 0;
            sel_b   = ($urandom % 20) != 0;
            sel_cn  = ($urandom % 20) == 0;
            bwe     = ($urandom % 3) == 0;
            lane_we = 4'($urandom);
            gwe     = ($urandom % 8) == 0;
            oe      = ($urandom % 8) != 0;
            zz      = ($urandom % 40) == 0;
            addr    = ADDR_W'($urandom);
            wd      = $urandom;
            step("R1");
        end

        summary();
    end

endmodule